// File: doc/BRIEF.md
# Streaming Ones' Complement Header Checksum

This unit folds a stream of 16-bit words into a running ones' complement sum. It is meant for packet headers. Any carry out of the top bit is fed straight back into bit 0 on the same cycle, so the sum never loses a carry. When the last word of a packet has been taken in, the unit presents the bitwise inverse of the sum as the checksum, together with a one-cycle strobe.

The same unit serves both sides of a link. On transmit, the checksum field is held at zero while the header is summed, and the result is written into that field. On receive, every word is summed, the checksum field included, and a pass flag reports whether the total came to all ones. All ones means the inverted result is zero.

Packets are framed by a start pulse and an end pulse. Each pulse may coincide with a data word. Idle cycles may fall anywhere inside a packet, and a new packet may start on the cycle right after the previous one ends.

Top module: `ocsum_stream`

## Requirements
- R1: While reset is held (active-low `rst_n`), and on the first cycle after it, `csum_o` is 0x0000, and `csum_vld_o` and `hdr_ok_o` are 0.
- R2: Each word taken in is added to the running sum as a 17-bit addition. Bit 16 of that addition is then added back into bit 0. For example, 0xFFFF plus 0x0001 gives 0x0001, and 0x8000 plus 0x8000 gives 0x0001.
- R3: `csum_vld_o` is high for exactly the one cycle after each cycle that has `eop_i` high, and is low at all other times.
- R4: A cycle with `word_vld_i` low leaves the sum unchanged, whatever value `word_i` carries.
- R5: `sop_i` resets the sum to zero. A word that arrives with `word_vld_i` on the same cycle as `sop_i` becomes the first word of the new packet.
- R6: A word that arrives with `word_vld_i` on the same cycle as `eop_i` is included in that packet's result. `sop_i` and `eop_i` high together with a valid word form a one-word packet.
- R7: On each end cycle, `csum_o` is loaded with the bitwise inverse of the final sum. In the same cycle, `hdr_ok_o` is set to 1 exactly when the final sum is 0xFFFF. Both outputs keep their values until the next end cycle.
- R8: The sum is also cleared after every end cycle. A packet that follows, with or without `sop_i`, therefore starts from zero, and `sop_i` may arrive on the cycle right after `eop_i`.
- R9: If the bytes of every input word are swapped, the checksum comes out with its bytes swapped.
- R10: A packet with no valid words (an end pulse with nothing since the last clear) yields checksum 0xFFFF with `hdr_ok_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 16 | Data word |
| word_vld_i | input | 1 | `word_i` is part of the packet this cycle |
| sop_i | input | 1 | Start-of-packet pulse; clears the sum |
| eop_i | input | 1 | End-of-packet pulse; closes the packet |
| csum_o | output | 16 | Inverted ones' complement sum of the last packet |
| csum_vld_o | output | 1 | One-cycle strobe: a new `csum_o` is present |
| hdr_ok_o | output | 1 | Last packet summed to all ones |

## Verification
The bench aims at carry wrap-around: word pairs whose sum overflows bit 15. A design that drops the end-around carry would report 0x0000 instead of 0x0001 for those pairs and would drift on long random packets. It also closes random headers with their own checksum word, where the receive flag must rise. An off-by-one in the inversion or the all-ones compare would show up there as a missing pass, or as a pass on an all-zero sum.

Framing corners get their own tests:
- one-word packets where start and end coincide;
- empty packets;
- packets sent right after another one ends, with no gap;
- packets with no start pulse at all.

A design that kept the previous total past the end pulse would corrupt the checksum of the following packet. A design that dropped a word sharing a cycle with a pulse would also give a wrong checksum. Idle cycles carrying random data are mixed into every packet, so a design that summed unqualified words would fail. Byte-swapped copies of random packets test that the result carries no hidden byte-order dependence.

// File: rtl/ocsum_stream.sv
module ocsum_stream #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         word_vld_i,
  input  logic         sop_i,
  input  logic         eop_i,
  output logic [W-1:0] csum_o,
  output logic         csum_vld_o,
  output logic         hdr_ok_o
);

  logic [W-1:0] acc;
  logic [W-1:0] base;
  logic [W:0]   raw;
  logic [W-1:0] folded;
  logic [W-1:0] sum_n;

  assign base   = sop_i ? '0 : acc;
  assign raw    = {1'b0, base} + {1'b0, word_i};
  assign folded = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  assign sum_n  = word_vld_i ? folded : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      csum_o     <= '0;
      csum_vld_o <= 1'b0;
      hdr_ok_o   <= 1'b0;
    end else begin
      acc        <= eop_i ? '0 : sum_n;
      csum_vld_o <= eop_i;
      if (eop_i) begin
        csum_o   <= ~sum_n;
        hdr_ok_o <= &sum_n;
      end
    end
  end

  // R3
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_i |=> csum_vld_o);
  // R3
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_i |=> !csum_vld_o);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_vld_i && !sop_i && !eop_i) |=> $stable(acc));
  // R5
  sop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_i && !word_vld_i && !eop_i) |=> (acc == '0));
  // R8
  eop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_i |=> (acc == '0));
  // R7
  ok_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_vld_o |-> (hdr_ok_o == (csum_o == '0)));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_i |=> ($stable(csum_o) && $stable(hdr_ok_o)));

endmodule

// File: tb/sim_ocsum_stream.sv
module sim_ocsum_stream;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] word_i;
  logic        word_vld_i, sop_i, eop_i;
  wire  [15:0] csum_o;
  wire         csum_vld_o, hdr_ok_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] pkt [0:39];
  int n;

  always #5 clk = ~clk;

  ocsum_stream u0 (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .sop_i(sop_i), .eop_i(eop_i), .csum_o(csum_o), .csum_vld_o(csum_vld_o),
    .hdr_ok_o(hdr_ok_o)
  );

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [15:0] pkt_sum();
    logic [15:0] s = 16'h0000;
    for (int i = 0; i < n; i++) s = oc_add(s, pkt[i]);
    return s;
  endfunction

  function automatic logic [15:0] bswap(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    word_vld_i = 1'b0; sop_i = 1'b0; eop_i = 1'b0; word_i = 16'($urandom);
  endtask

  task automatic send(input bit use_sop, input bit b2b, input int gap_pct, input string tag);
    logic [15:0] s;
    logic [15:0] held;
    bit sop_pend;
    bit eop_with_word;
    s = pkt_sum();
    sop_pend = use_sop;
    eop_with_word = ($urandom % 2) == 1;
    if (use_sop && ($urandom % 2) == 1) begin
      @(negedge clk); idle(); sop_i = 1'b1; sop_pend = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        @(negedge clk); idle();
      end
      @(negedge clk); idle();
      word_i = pkt[i]; word_vld_i = 1'b1; sop_i = sop_pend; sop_pend = 1'b0;
      eop_i = (i == n - 1) && eop_with_word;
    end
    if (!eop_with_word || n == 0) begin
      @(negedge clk); idle(); eop_i = 1'b1; sop_i = sop_pend;
    end
    @(posedge clk); #1;
    chk(csum_vld_o == 1'b1, {tag, " strobe R3"}, {15'd0, csum_vld_o}, 16'h0001);
    chk(csum_o == ~s, {tag, " checksum"}, csum_o, ~s);
    chk(hdr_ok_o == (s == 16'hFFFF), {tag, " pass flag R7"}, {15'd0, hdr_ok_o}, {15'd0, s == 16'hFFFF});
    if (!b2b) begin
      held = csum_o;
      @(negedge clk); idle();
      @(posedge clk); #1;
      chk(csum_vld_o == 1'b0, {tag, " strobe one cycle R3"}, {15'd0, csum_vld_o}, 16'h0000);
      chk(csum_o == held, {tag, " result held R7"}, csum_o, held);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] s0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; idle();
    repeat (3) @(posedge clk);
    #1;
    chk(csum_o == 16'h0000 && !csum_vld_o && !hdr_ok_o, "R1 reset outputs",
        {csum_o[15:2], csum_vld_o, hdr_ok_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!csum_vld_o && !hdr_ok_o && csum_o == 16'h0000, "R1 after release",
        csum_o, 16'h0000);

    n = 2; pkt[0] = 16'hFFFF; pkt[1] = 16'h0001;
    send(1, 0, 0, "R2 wrap FFFF+0001");
    chk(csum_o == 16'hFFFE, "R2 wrap value", csum_o, 16'hFFFE);
    n = 2; pkt[0] = 16'h8000; pkt[1] = 16'h8000;
    send(1, 0, 20, "R2 wrap 8000+8000");
    chk(csum_o == 16'hFFFE, "R2 wrap value b", csum_o, 16'hFFFE);
    n = 0;
    send(1, 0, 0, "R10 empty");
    chk(csum_o == 16'hFFFF && !hdr_ok_o, "R10 empty result", csum_o, 16'hFFFF);
    n = 1; pkt[0] = 16'hFFFF;
    send(1, 0, 0, "R6 R7 single all-ones");
    chk(hdr_ok_o == 1'b1, "R7 single all-ones ok", {15'd0, hdr_ok_o}, 16'h0001);
    n = 3; pkt[0] = 16'h1234; pkt[1] = 16'hF00D; pkt[2] = 16'hBEEF;
    send(1, 1, 0, "R8 b2b first");
    n = 2; pkt[0] = 16'h0F0F; pkt[1] = 16'h7777;
    send(1, 0, 0, "R5 R8 b2b second");
    n = 2; pkt[0] = 16'hA5A5; pkt[1] = 16'h0102;
    send(0, 0, 30, "R8 no start pulse");

    for (int it = 0; it < 40; it++) begin
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) pkt[i] = 16'($urandom);
      if (it % 3 == 0) begin
        pkt[n] = ~pkt_sum();
        n = n + 1;
        send(($urandom % 4) != 0, ($urandom % 2) == 1, 30, "R7 self-closed header");
      end else if (it % 5 == 1) begin
        s0 = pkt_sum();
        for (int i = 0; i < n; i++) pkt[i] = bswap(pkt[i]);
        send(1, 0, 30, "R9 swapped");
        chk(csum_o == ~bswap(s0), "R9 byte order", csum_o, ~bswap(s0));
      end else begin
        send(($urandom % 4) != 0, ($urandom % 2) == 1, 30, "R2 R4 random");
      end
    end

    @(negedge clk); idle();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule